// File: doc/BRIEF.md
# Registered 32-bit Barrel Shifter with Condition Flags

This block shifts a 32-bit operand left or right by 0 to 31 places in one pass and also produces four condition flags: zero, sign, carry and overflow. It has three kinds of shift. A logical left shift fills with zeros. A logical right shift fills with zeros. An arithmetic right shift fills with copies of the operand's top bit. The shift distance comes from one of two sources: a 5-bit immediate field, or the low bits of a general register value.

The carry flag holds the last bit pushed out of the word. For a shift of zero it is cleared. The overflow flag is cleared by every shift. The result and the flags are registered, so a new operation can start on every cycle. `out_valid` marks the cycle in which the registered result belongs to the operation sampled one cycle earlier.

Top module: `bshift_top`

## Requirements
- R1: `mode` selects the operation. Code 0 is a logical left shift, code 1 a logical right shift and code 2 an arithmetic right shift. Code 3 behaves exactly like code 1.
- R2: When `amt_sel` is 0, the distance is `amt_imm`, zero-extended. When `amt_sel` is 1, the distance is bits [4:0] of `amt_reg`, and bits [31:5] of `amt_reg` have no effect on the result or the flags.
- R3: A logical left shift by n (n > 0) gives `data_in << n` and sets `flag_cy` to bit 32-n of `data_in`.
- R4: A logical right shift by n (n > 0) fills the vacated high bits with zeros and sets `flag_cy` to bit n-1 of `data_in`.
- R5: An arithmetic right shift by n (n > 0) fills the vacated high bits with bit 31 of `data_in` and sets `flag_cy` to bit n-1 of `data_in`.
- R6: A distance of 0 returns `data_in` unchanged in every mode and clears `flag_cy`.
- R7: `flag_z` is 1 exactly when the result is zero. `flag_s` equals bit 31 of the result.
- R8: `flag_ov` is 0 after every shift.
- R9: After a cycle with `in_valid` high, `out_valid` is high and the outputs show that operation. After a cycle with `in_valid` low, `out_valid` is low and `data_out` and the flags keep their previous values.
- R10: While `rst_n` is low, `out_valid`, `data_out` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample the operands on this edge |
| mode | input | 2 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 logical right |
| amt_sel | input | 1 | Distance source: 0 immediate, 1 register |
| amt_imm | input | 5 | Immediate shift distance |
| amt_reg | input | 32 | Register value; its low 5 bits give the distance |
| data_in | input | 32 | Operand to shift |
| out_valid | output | 1 | Registered result is new this cycle |
| data_out | output | 32 | Shifted result |
| flag_z | output | 1 | Result is zero |
| flag_s | output | 1 | Result bit 31 |
| flag_cy | output | 1 | Last bit shifted out |
| flag_ov | output | 1 | Overflow, always cleared by a shift |

## Verification
The bound checker tests these rules on every cycle:
- the zero and sign flags agree with the registered result;
- `out_valid` follows `in_valid` by exactly one cycle;
- the outputs hold while idle;
- a zero distance passes the operand through with the carry cleared;
- an arithmetic right shift of a negative operand stays negative.

Some behaviour can only be shown by the bench's scenarios, where a reference model computes the expected values:
- the exact bit pattern and carry for every distance in every mode;
- the claim that the high register bits have no effect;
- the constant clearing of overflow;
- the reset values.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    typedef enum logic [1:0] {
        SH_LEFT      = 2'd0,
        SH_RIGHT_LOG = 2'd1,
        SH_RIGHT_ARI = 2'd2,
        SH_RIGHT_ALT = 2'd3
    } shift_mode_e;

    typedef struct packed {
        logic        valid;
        logic [31:0] data;
        logic        z;
        logic        s;
        logic        cy;
        logic        ov;
    } out_state_t;

endpackage

// File: rtl/bshift_amount.sv
module bshift_amount #(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic             use_reg,
    input  logic [AMT_W-1:0] imm,
    input  logic [WIDTH-1:0] reg_val,
    output logic [AMT_W-1:0] amt
);
    logic [WIDTH-1:0] reg_masked;

    always_comb begin
        // only the low AMT_W bits of the register take part
        reg_masked = reg_val & WIDTH'(WIDTH - 1);
        amt        = use_reg ? reg_masked[AMT_W-1:0] : imm;
    end
endmodule

// File: rtl/bshift_core.sv
module bshift_core #(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data,
    input  logic [AMT_W-1:0] amt,
    input  logic             go_left,
    input  logic             fill,
    output logic [WIDTH-1:0] result,
    output logic             carry
);
    // One guard bit per chain: it catches the last bit that leaves the word.
    logic [WIDTH:0] lchain [0:AMT_W];
    logic [WIDTH:0] rchain [0:AMT_W];

    assign lchain[0] = {1'b0, data};
    assign rchain[0] = {data, 1'b0};

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int S = 1 << k;
        assign lchain[k+1] = amt[k] ? {lchain[k][WIDTH-S:0], {S{1'b0}}} : lchain[k];
        assign rchain[k+1] = amt[k] ? {{S{fill}}, rchain[k][WIDTH:S]}   : rchain[k];
    end

    always_comb begin
        if (go_left) begin
            result = lchain[AMT_W][WIDTH-1:0];
            carry  = lchain[AMT_W][WIDTH];
        end else begin
            result = rchain[AMT_W][WIDTH:1];
            carry  = rchain[AMT_W][0];
        end
    end
endmodule

// File: rtl/bshift_flags.sv
module bshift_flags #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] result,
    output logic             z,
    output logic             s,
    output logic             ov
);
    always_comb begin
        z  = (result == '0);
        s  = result[WIDTH-1];
        ov = 1'b0;
    end
endmodule

// File: rtl/bshift_top.sv
module bshift_top
    import bshift_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [1:0]  mode,
    input  logic        amt_sel,
    input  logic [4:0]  amt_imm,
    input  logic [31:0] amt_reg,
    input  logic [31:0] data_in,
    output logic        out_valid,
    output logic [31:0] data_out,
    output logic        flag_z,
    output logic        flag_s,
    output logic        flag_cy,
    output logic        flag_ov
);
    localparam int WIDTH = 32;
    localparam int AMT_W = $clog2(WIDTH);

    shift_mode_e      mode_e;
    logic [AMT_W-1:0] amt;
    logic             go_left;
    logic             fill;
    logic [WIDTH-1:0] sh_res;
    logic             sh_cy;
    logic             f_z, f_s, f_ov;
    out_state_t       st_d, st_q;

    always_comb begin
        mode_e  = shift_mode_e'(mode);
        go_left = (mode_e == SH_LEFT);
        fill    = (mode_e == SH_RIGHT_ARI) & data_in[WIDTH-1];
    end

    bshift_amount #(.WIDTH(WIDTH)) u_amt (
        .use_reg (amt_sel),
        .imm     (amt_imm),
        .reg_val (amt_reg),
        .amt     (amt)
    );

    bshift_core #(.WIDTH(WIDTH)) u_core (
        .data    (data_in),
        .amt     (amt),
        .go_left (go_left),
        .fill    (fill),
        .result  (sh_res),
        .carry   (sh_cy)
    );

    bshift_flags #(.WIDTH(WIDTH)) u_flags (
        .result (sh_res),
        .z      (f_z),
        .s      (f_s),
        .ov     (f_ov)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.data = sh_res;
            st_d.z    = f_z;
            st_d.s    = f_s;
            st_d.cy   = sh_cy;
            st_d.ov   = f_ov;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign data_out  = st_q.data;
    assign flag_z    = st_q.z;
    assign flag_s    = st_q.s;
    assign flag_cy   = st_q.cy;
    assign flag_ov   = st_q.ov;
endmodule

// File: rtl/bshift_checker.sv
module bshift_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  mode,
    input logic        amt_sel,
    input logic [4:0]  amt_imm,
    input logic [31:0] amt_reg,
    input logic [31:0] data_in,
    input logic        out_valid,
    input logic [31:0] data_out,
    input logic        flag_z,
    input logic        flag_s,
    input logic        flag_cy
);
    logic [4:0] eff_amt;
    assign eff_amt = amt_sel ? amt_reg[4:0] : amt_imm;

    a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_z == (data_out == 32'h0)));

    a_r7_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_s == data_out[31]));

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(data_out) && $stable(flag_cy)));

    a_r6_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && eff_amt == 5'd0) |=> (data_out == $past(data_in) && !flag_cy));

    a_r5_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd2 && data_in[31]) |=> data_out[31]);
endmodule

bind bshift_top bshift_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .amt_sel   (amt_sel),
    .amt_imm   (amt_imm),
    .amt_reg   (amt_reg),
    .data_in   (data_in),
    .out_valid (out_valid),
    .data_out  (data_out),
    .flag_z    (flag_z),
    .flag_s    (flag_s),
    .flag_cy   (flag_cy)
);

// File: tb/bshift_top_test.sv
module bshift_top_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  mode;
        logic        sel;
        logic [4:0]  imm;
        logic [31:0] rv;
        logic [31:0] din;
        logic [31:0] exp_d;
        logic        exp_z;
        logic        exp_s;
        logic        exp_cy;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 1'b0, 5'd4,  32'h0,         32'h0000_00F1, 32'h0000_0F10, 1'b0, 1'b0, 1'b0},
        '{2'd1, 1'b0, 5'd1,  32'h0,         32'h0000_0003, 32'h0000_0001, 1'b0, 1'b0, 1'b1},
        '{2'd2, 1'b0, 5'd4,  32'h0,         32'h8000_0010, 32'hF800_0001, 1'b0, 1'b1, 1'b0},
        '{2'd2, 1'b0, 5'd31, 32'h0,         32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0},
        '{2'd0, 1'b0, 5'd1,  32'h0,         32'h8000_0000, 32'h0000_0000, 1'b1, 1'b0, 1'b1},
        '{2'd1, 1'b1, 5'd9,  32'hFFFF_FFE3, 32'h0000_00FF, 32'h0000_001F, 1'b0, 1'b0, 1'b1},
        '{2'd3, 1'b0, 5'd8,  32'h0,         32'hF000_0000, 32'h00F0_0000, 1'b0, 1'b0, 1'b0},
        '{2'd0, 1'b1, 5'd7,  32'h0000_0020, 32'h1234_5678, 32'h1234_5678, 1'b0, 1'b0, 1'b0},
        '{2'd1, 1'b0, 5'd31, 32'h0,         32'h8000_0000, 32'h0000_0001, 1'b0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        amt_sel = 1'b0;
    logic [4:0]  amt_imm = 5'd0;
    logic [31:0] amt_reg = 32'h0;
    logic [31:0] data_in = 32'h0;
    logic        out_valid;
    logic [31:0] data_out;
    logic        flag_z, flag_s, flag_cy, flag_ov;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bshift_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .amt_sel(amt_sel), .amt_imm(amt_imm), .amt_reg(amt_reg),
        .data_in(data_in), .out_valid(out_valid), .data_out(data_out),
        .flag_z(flag_z), .flag_s(flag_s), .flag_cy(flag_cy), .flag_ov(flag_ov)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model: one bit position per step.
    task automatic ref_shift(input logic [1:0] m, input int n, input logic [31:0] d,
                             output logic [31:0] r, output logic cy);
        r = d;
        cy = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (m == 2'd0) begin
                cy = r[31];
                r = {r[30:0], 1'b0};
            end else begin
                cy = r[0];
                r = {(m == 2'd2) ? r[31] : 1'b0, r[31:1]};
            end
        end
    endtask

    task automatic apply(input logic [1:0] m, input logic s, input logic [4:0] im,
                         input logic [31:0] rv, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; mode = m; amt_sel = s; amt_imm = im; amt_reg = rv; data_in = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] er;
        logic        ecy;
        logic [31:0] held;
        logic [31:0] pats [3];
        pats[0] = 32'hA5C3_0F81;
        pats[1] = 32'h7FFF_0001;
        pats[2] = 32'h8000_0001;

        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 valid", {31'h0, out_valid}, 32'h0);
        check("R10 data", data_out, 32'h0);
        check("R10 flags", {28'h0, flag_z, flag_s, flag_cy, flag_ov}, 32'h0);
        rst_n = 1'b1;

        // Table of directed vectors (R1..R7)
        for (int v = 0; v < NVEC; v++) begin
            apply(VECS[v].mode, VECS[v].sel, VECS[v].imm, VECS[v].rv, VECS[v].din);
            check("R1/R3/R4/R5 table data", data_out, VECS[v].exp_d);
            check("R7 table z/s", {30'h0, flag_z, flag_s}, {30'h0, VECS[v].exp_z, VECS[v].exp_s});
            check("R3/R4/R5/R6 table cy", {31'h0, flag_cy}, {31'h0, VECS[v].exp_cy});
            check("R8 table ov", {31'h0, flag_ov}, 32'h0);
            check("R9 valid", {31'h0, out_valid}, 32'h1);
        end

        // Every mode, every distance, several patterns, against the model
        for (int m = 0; m < 4; m++) begin
            for (int n = 0; n < 32; n++) begin
                for (int p = 0; p < 3; p++) begin
                    ref_shift(2'(m), n, pats[p], er, ecy);
                    apply(2'(m), 1'b0, 5'(n), 32'h0, pats[p]);
                    check("R1/R3/R4/R5 sweep data", data_out, er);
                    check("R3/R4/R5/R6 sweep cy", {31'h0, flag_cy}, {31'h0, ecy});
                    check("R7 sweep z/s", {30'h0, flag_z, flag_s},
                          {30'h0, (er == 32'h0), er[31]});
                    check("R8 sweep ov", {31'h0, flag_ov}, 32'h0);
                end
                // R2: the register source with junk in the upper bits
                ref_shift(2'(m), n, pats[2], er, ecy);
                apply(2'(m), 1'b1, 5'(~n), {27'h5A5A5A5 ^ 27'(n), 5'(n)}, pats[2]);
                check("R2 reg source data", data_out, er);
                check("R2 reg source cy", {31'h0, flag_cy}, {31'h0, ecy});
            end
        end

        // R9: idle cycle holds outputs while inputs change
        apply(2'd0, 1'b0, 5'd3, 32'h0, 32'h0000_0011);
        held = data_out;
        @(negedge clk);
        data_in = 32'hFFFF_FFFF; mode = 2'd2; amt_imm = 5'd1;
        @(negedge clk);
        check("R9 idle valid", {31'h0, out_valid}, 32'h0);
        check("R9 idle hold", data_out, held);
        check("R9 held value", held, 32'h0000_0088);

        // R6: zero distance in arithmetic mode on negative data
        apply(2'd2, 1'b0, 5'd0, 32'h0, 32'h8000_0001);
        check("R6 zero pass", data_out, 32'h8000_0001);
        check("R6 zero cy", {31'h0, flag_cy}, 32'h0);

        // R10: reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 re-reset data", data_out, 32'h0);
        check("R10 re-reset valid", {31'h0, out_valid}, 32'h0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule